// File: doc/BRIEF.md
# Multi-channel PPM pulse train generator

This block turns a set of channel widths, given in microseconds, into one combined pulse-position-modulated line. A frame opens with a high marker pulse; every following marker rises exactly one channel width after the one before it, so N channels take N+1 markers. Each marker is a fixed-length high pulse, and after the last marker the line rests low in a sync gap before the next frame opens.

Time advances only on a one-cycle microsecond enable (`tick_us`), so the block runs from any system clock. All durations below are counted in ticks of that enable. Widths are clamped into the legal range and captured once, at the moment a frame opens. A mode input picks one of two frame spacings: variable, where the sync gap has a fixed length and the frame length follows the channel widths; or constant, where frames open at a fixed period of N × maximum width + sync gap.

Top module: `ppm_train_gen`

## Requirements
- R1: While `rst` is high and afterwards until the first frame opens, `ppm_out` is low; the first frame opens (rising edge) on the SYNC_US-th tick after reset is released.
- R2: Each frame has N_CH+1 rising edges; rising edge k+1 comes exactly width(k) ticks after rising edge k, where channel k's width is taken from `ch_width[k*W +: W]`.
- R3: Every marker stays high for exactly MARK_US ticks after its rising edge.
- R4: With `cycle_const` = 0, the line stays low for exactly SYNC_US ticks between the end of a frame's final marker and the next frame's first rising edge.
- R5: With `cycle_const` = 1, consecutive frames open exactly N_CH × MAX_US + SYNC_US ticks apart.
- R6: Channel widths are sampled on the tick that opens a frame; changes to `ch_width` during a frame take effect only from the next frame.
- R7: A width below MIN_US is used as MIN_US and a width above MAX_US is used as MAX_US.
- R8: The sequence advances only on cycles where `tick_us` is 1; `ppm_out` changes only on such cycles, so all durations scale with the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle time-base enable, one per microsecond |
| cycle_const | input | 1 | 0: fixed sync gap, 1: fixed frame period |
| ch_width | input | N_CH*W | Channel widths in ticks, channel k at bits [k*W +: W] |
| ppm_out | output | 1 | Registered PPM line |

## Verification
The hardest situation to reach is the frame-boundary capture: a width change must land after the opening tick of a frame yet before its slots have played out, and its absence must be visible in that frame while its presence shows in the next. The bench waits on the observed rising edge that opens a frame, changes the widths (including out-of-range ones) in the very next cycle, and then compares the edge timings of both frames. Mode switching is reached the same way, flipping `cycle_const` just after a frame opens so the next opening is decided by the period rule, and the tick rate is slowed mid-run to show that tick-counted timings stay put while cycle-counted ones stretch.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic {
    ST_SYNC = 1'b0,
    ST_SLOT = 1'b1
  } ppm_state_e;
endpackage

// File: rtl/ppm_clamp.sv
module ppm_clamp #(
  parameter int N_CH   = 8,
  parameter int W      = 12,
  parameter int MIN_US = 800,
  parameter int MAX_US = 2200
) (
  input  logic [N_CH*W-1:0] raw,
  output logic [N_CH*W-1:0] lim
);
  localparam logic [W-1:0] LO = W'(MIN_US);
  localparam logic [W-1:0] HI = W'(MAX_US);

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    logic [W-1:0] v;
    assign v = raw[g*W +: W];
    assign lim[g*W +: W] = (v < LO) ? LO : ((v > HI) ? HI : v);
  end
endmodule

// File: rtl/ppm_width_bank.sv
module ppm_width_bank #(
  parameter int N_CH  = 8,
  parameter int W     = 12,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [N_CH*W-1:0] d_flat,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [W-1:0]      rd_width
);
  logic [W-1:0] bank [N_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) bank[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < N_CH; i++) bank[i] <= d_flat[i*W +: W];
    end
  end

  always_comb begin
    rd_width = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_idx == IDX_W'(i)) rd_width = bank[i];
  end
endmodule

// File: rtl/ppm_sequencer.sv
module ppm_sequencer
  import ppm_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int W       = 12,
  parameter int MARK_US = 500,
  parameter int SYNC_US = 5000,
  parameter int MAX_US  = 2200,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cycle_const,
  input  logic [W-1:0]     slot_width,
  output logic [IDX_W-1:0] rd_idx,
  output logic             load,
  output logic             ppm_out
);
  localparam int PERIOD = N_CH * MAX_US + SYNC_US;
  localparam int GAP_W  = $clog2(SYNC_US + 1);
  localparam int PER_W  = $clog2(PERIOD + 1);
  localparam logic [W-1:0]     MARK_LAST = W'(MARK_US - 1);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(SYNC_US - 1);
  localparam logic [PER_W-1:0] PER_LAST  = PER_W'(PERIOD - 1);
  localparam logic [PER_W-1:0] PER_INIT  = PER_W'(PERIOD - SYNC_US);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(N_CH);

  ppm_state_e       state;
  logic [GAP_W-1:0] gap_cnt;
  logic [PER_W-1:0] per_cnt;
  logic [W-1:0]     slot_cnt;
  logic [IDX_W-1:0] idx;
  logic             out_q;
  logic             open_now;

  assign open_now = (state == ST_SYNC) &&
                    (cycle_const ? (per_cnt == PER_LAST) : (gap_cnt == GAP_LAST));
  assign load    = tick && open_now;
  assign rd_idx  = idx;
  assign ppm_out = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SYNC;
      gap_cnt  <= '0;
      per_cnt  <= PER_INIT;
      slot_cnt <= '0;
      idx      <= '0;
      out_q    <= 1'b0;
    end else if (tick) begin
      if (per_cnt != PER_LAST) per_cnt <= per_cnt + 1'b1;
      case (state)
        ST_SYNC: begin
          if (open_now) begin
            state    <= ST_SLOT;
            idx      <= '0;
            slot_cnt <= '0;
            out_q    <= 1'b1;
            per_cnt  <= '0;
          end else if (gap_cnt != GAP_LAST) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_SLOT: begin
          if (idx == LAST_IDX) begin
            if (slot_cnt == MARK_LAST) begin
              out_q   <= 1'b0;
              state   <= ST_SYNC;
              gap_cnt <= '0;
            end else begin
              slot_cnt <= slot_cnt + 1'b1;
            end
          end else if (slot_cnt == slot_width - 1'b1) begin
            out_q    <= 1'b1;
            idx      <= idx + 1'b1;
            slot_cnt <= '0;
          end else begin
            if (slot_cnt == MARK_LAST) out_q <= 1'b0;
            slot_cnt <= slot_cnt + 1'b1;
          end
        end
        default: state <= ST_SYNC;
      endcase
    end
  end
endmodule

// File: rtl/ppm_train_gen.sv
module ppm_train_gen #(
  parameter int N_CH    = 8,
  parameter int W       = 12,
  parameter int MARK_US = 500,
  parameter int SYNC_US = 5000,
  parameter int MIN_US  = 800,
  parameter int MAX_US  = 2200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              cycle_const,
  input  logic [N_CH*W-1:0] ch_width,
  output logic              ppm_out
);
  localparam int IDX_W = $clog2(N_CH + 1);

  logic [N_CH*W-1:0] lim_flat;
  logic [IDX_W-1:0]  rd_idx;
  logic [W-1:0]      slot_width;
  logic              load;

  ppm_clamp #(.N_CH(N_CH), .W(W), .MIN_US(MIN_US), .MAX_US(MAX_US)) u_clamp (
    .raw (ch_width),
    .lim (lim_flat)
  );

  ppm_width_bank #(.N_CH(N_CH), .W(W), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .d_flat   (lim_flat),
    .rd_idx   (rd_idx),
    .rd_width (slot_width)
  );

  ppm_sequencer #(
    .N_CH(N_CH), .W(W), .MARK_US(MARK_US), .SYNC_US(SYNC_US),
    .MAX_US(MAX_US), .IDX_W(IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_us),
    .cycle_const (cycle_const),
    .slot_width  (slot_width),
    .rd_idx      (rd_idx),
    .load        (load),
    .ppm_out     (ppm_out)
  );
endmodule

// File: rtl/ppm_train_gen_chk.sv
module ppm_train_gen_chk #(
  parameter int N_CH    = 8,
  parameter int MARK_US = 500,
  parameter int SYNC_US = 5000,
  parameter int MAX_US  = 2200
) (
  input logic clk,
  input logic rst,
  input logic tick_us,
  input logic cycle_const,
  input logic ppm_out
);
  localparam int PERIOD = N_CH * MAX_US + SYNC_US;

  logic out_d;
  int   run;
  int   ft;
  int   rc;
  logic seen;
  logic const_run;
  logic frame_rise;

  assign frame_rise = ppm_out && !out_d && (rc == 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_d <= 1'b0; run <= 0; ft <= 0; rc <= 0;
      seen <= 1'b0; const_run <= 1'b0;
    end else begin
      out_d <= ppm_out;
      if (ppm_out != out_d) run <= tick_us ? 1 : 0;
      else                  run <= run + (tick_us ? 1 : 0);
      if (ppm_out && !out_d) rc <= (rc == N_CH) ? 0 : rc + 1;
      if (frame_rise) begin
        ft        <= tick_us ? 1 : 0;
        seen      <= 1'b1;
        const_run <= 1'b1;
      end else begin
        ft <= ft + (tick_us ? 1 : 0);
        if (!cycle_const) const_run <= 1'b0;
      end
    end
  end

  // R1: output low after a reset cycle
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !ppm_out);

  // R3: marker length in ticks
  p_mark_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ppm_out) |-> run == MARK_US);

  // R4: sync gap before a frame opened by the gap rule
  p_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_rise && !$past(cycle_const)) |-> run >= SYNC_US);

  // R5: frame spacing under the period rule
  p_period_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_rise && $past(cycle_const) && const_run && seen) |-> ft == PERIOD);
endmodule

bind ppm_train_gen ppm_train_gen_chk #(
  .N_CH(N_CH), .MARK_US(MARK_US), .SYNC_US(SYNC_US), .MAX_US(MAX_US)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_us     (tick_us),
  .cycle_const (cycle_const),
  .ppm_out     (ppm_out)
);

// File: tb/test_ppm_train_gen.sv
module test_ppm_train_gen;
  localparam int N_CH = 4, W = 12, MARK = 5, SYNC = 50, MINW = 8, MAXW = 22;
  localparam int PERIOD = N_CH * MAXW + SYNC;

  logic clk = 1'b0, rst = 1'b1, tick_us = 1'b0, cycle_const = 1'b0;
  logic [N_CH*W-1:0] ch_width = '0;
  logic ppm_out;

  ppm_train_gen #(.N_CH(N_CH), .W(W), .MARK_US(MARK), .SYNC_US(SYNC),
                  .MIN_US(MINW), .MAX_US(MAXW)) i_ppm_train_gen (
    .clk(clk), .rst(rst), .tick_us(tick_us), .cycle_const(cycle_const),
    .ch_width(ch_width), .ppm_out(ppm_out));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int tick_every = 1, cyc = 0, tk = 0, bad_edges = 0;
  logic tick_at_edge = 1'b0, prev = 1'b0;
  int rise_t[128], fall_t[128], rise_c[128], fall_c[128];
  int nr = 0, nf = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_us <= ((cyc + 1) % tick_every) == 0;
  end

  always @(posedge clk) begin
    tick_at_edge <= tick_us;
    if (rst) tk <= 0;
    else if (tick_us) tk <= tk + 1;
  end

  always @(negedge clk) begin
    if (!rst && ppm_out !== prev) begin
      if (!tick_at_edge) bad_edges = bad_edges + 1;
      if (ppm_out) begin rise_t[nr] = tk; rise_c[nr] = cyc; nr = nr + 1; end
      else begin fall_t[nf] = tk; fall_c[nf] = cyc; nf = nf + 1; end
      prev = ppm_out;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_w(int a, int b, int c, int d);
    ch_width = {W'(d), W'(c), W'(b), W'(a)};
  endtask

  task automatic wait_falls(int n);
    while (nf < n) @(negedge clk);
  endtask
  task automatic wait_rises(int n);
    while (nr < n) @(negedge clk);
  endtask

  // R2 / R3: one frame's edge spacing and marker lengths
  task automatic check_frame(int f, int a, int b, int c, int d, string tag);
    int w[4];
    w = '{a, b, c, d};
    wait_falls(5 * f + 5);
    for (int i = 1; i <= N_CH; i++)
      chk({"R2 spacing ", tag}, rise_t[5*f+i] - rise_t[5*f+i-1], w[i-1]);
    for (int i = 0; i <= N_CH; i++)
      chk({"R3 mark ", tag}, fall_t[5*f+i] - rise_t[5*f+i], MARK);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 low in reset", int'(ppm_out), 0);
    end
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 low before first frame", int'(ppm_out), 0);
    wait_rises(1);
    chk("R1 first open tick", rise_t[0], SYNC);
  endtask

  task automatic t_variable;
    check_frame(0, 10, 15, 20, 12, "frame0");
    wait_rises(6);
    chk("R4 gap frame0", rise_t[5] - fall_t[4], SYNC);
    chk("R2 markers per frame", nf, 5);
  endtask

  task automatic t_latch_clamp;
    wait_rises(11);
    set_w(3, 30, 8, 22);
    check_frame(2, 10, 15, 20, 12, "R6 old widths kept");
    check_frame(3, 8, 22, 8, 22, "R7 clamped");
    wait_rises(21);
    chk("R4 gap frame3", rise_t[20] - fall_t[19], SYNC);
  endtask

  task automatic t_constant;
    cycle_const = 1'b1;
    set_w(8, 8, 8, 8);
    wait_rises(36);
    chk("R5 period f4-f5", rise_t[25] - rise_t[20], PERIOD);
    chk("R5 period f5-f6", rise_t[30] - rise_t[25], PERIOD);
    chk("R5 period f6-f7", rise_t[35] - rise_t[30], PERIOD);
    check_frame(5, 8, 8, 8, 8, "const frame");
  endtask

  task automatic t_tick_rate;
    cycle_const = 1'b0;
    set_w(10, 15, 20, 12);
    tick_every = 3;
    check_frame(8, 10, 15, 20, 12, "R8 slow tick");
    wait_rises(46);
    chk("R4 gap after const frame", rise_t[40] - fall_t[39], SYNC);
    chk("R4 gap slow tick", rise_t[45] - fall_t[44], SYNC);
    chk("R8 mark cycles", fall_c[40] - rise_c[40], 3 * MARK);
    chk("R8 edges only on tick", bad_edges, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    set_w(10, 15, 20, 12);
    t_reset;
    t_variable;
    t_latch_clamp;
    t_constant;
    t_tick_rate;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule